// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides when the gate of one secondary-side synchronous rectifier switch is on. It works from comparator flags that are already digital and synchronised to the system clock. One flag reports that the drain-source voltage is deep enough below zero to turn the switch on. One reports that it has risen above the turn-off level. One reports that it has crossed the positive re-arm level. All timing is counted in system clock cycles.

After a turn-on, the turn-off flag is masked for a programmable minimum on-time, so that ringing cannot cut the pulse short. After a turn-off caused by the comparator, the turn-on flag is blanked for a window. A re-arm crossing ends that window early. A separate direct turn-off input overrides everything while it is high. Its rising edge alone returns the sequencer to the armed state and clears both timers. A gate-allow input from a mode supervisor masks the output. A one-cycle strobe reports the end of every minimum on-time, together with the turn-off flag sampled at that moment, so the supervisor can decide whether to allow the next cycle.

Top module: `sr_gate_seq`

## Requirements
- R1: In the armed state, `vds_on_i` high with `sync_i` low makes `gate_o` high from the next clock cycle.
- R2: After turn-on, `vds_off_i` is ignored for `mot_cyc_i` cycles. A value of 0 acts as 1.
- R3: Once the minimum on-time has expired, `vds_off_i` high makes `gate_o` low from the next cycle. If `vds_off_i` is high in the expiry cycle itself, the gate drops at that same edge.
- R4: After a comparator turn-off, `vds_on_i` is ignored for the blanking length. The sequencer re-arms at the edge that ends the window, and a held `vds_on_i` turns the gate on one cycle later.
- R5: During blanking, `vds_rst_i` high re-arms the sequencer at the next edge, ending the window early.
- R6: `blank_cyc_i` equal to 0 selects the default blanking length, CLK_KHZ*BLANK_NS/10^6 cycles. That is 850 cycles with the default parameters.
- R7: `sync_i` high forces `gate_o` low in the same cycle, whatever state the sequencer is in.
- R8: A rising edge of `sync_i` returns the sequencer to the armed state from any state and clears both timers, so no blanking follows. While `sync_i` stays high, no turn-on happens.
- R9: `gate_o` is low whenever `allow_i` is low. The sequence keeps running underneath.
- R10: `mot_end_o` pulses for exactly one cycle after each minimum on-time expiry. `mot_end_val_o` then holds `vds_off_i` as sampled at the expiry edge. No pulse is given when `sync_i` cuts the on-time short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vds_on_i | input | 1 | Drain-source below turn-on threshold |
| vds_off_i | input | 1 | Drain-source above turn-off threshold |
| vds_rst_i | input | 1 | Drain-source above re-arm threshold |
| sync_i | input | 1 | Synchronised direct turn-off request |
| allow_i | input | 1 | Gate allowed by mode supervisor |
| mot_cyc_i | input | MOT_W | Minimum on-time in cycles |
| blank_cyc_i | input | BLK_W | Blanking length in cycles, 0 selects default |
| gate_o | output | 1 | Gate enable |
| mot_end_o | output | 1 | One-cycle strobe at minimum on-time end |
| mot_end_val_o | output | 1 | Turn-off flag sampled at minimum on-time end |

## Verification
State changes caused by the comparator flags, the rising edge of `sync_i`, and timer expiry appear on `gate_o` one clock edge after the input is sampled. The level of `sync_i` and of `allow_i` acts on `gate_o` combinationally, in the same cycle. `mot_end_o` and `mot_end_val_o` are registered, so they are valid in the cycle after the expiry edge. The bench drives inputs just after a rising edge and samples one edge later, which matches this latency. The timer windows are checked at their exact cycle counts, including the last blanked cycle and the first cycle that turns the gate on again.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_MOT   = 2'd1,
    ST_ON    = 2'd2,
    ST_BLANK = 2'd3
  } sr_st_e;
endpackage

// File: rtl/sr_edge_det.sv
module sr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/sr_down_timer.sv
module sr_down_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         run_i,
  output logic         done_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (load_i)               cnt_q <= (val_i == '0) ? ONE : val_i;
    else if (run_i && cnt_q > ONE) cnt_q <= cnt_q - ONE;
  end

  // last cycle of the window
  assign done_o = (cnt_q <= ONE);
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import sr_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   vds_on_i,
  input  logic   vds_off_i,
  input  logic   vds_rst_i,
  input  logic   sync_i,
  input  logic   sync_rise_i,
  input  logic   mot_done_i,
  input  logic   blk_done_i,
  output logic   mot_load_o,
  output logic   blk_load_o,
  output logic   tmr_clr_o,
  output logic   mot_run_o,
  output logic   blk_run_o,
  output logic   gate_on_o,
  output logic   mot_end_o,
  output logic   mot_end_val_o,
  output sr_st_e st_o
);
  sr_st_e st_q, st_d;
  logic   strobe;
  logic   me_q, mv_q;

  always_comb begin
    st_d       = st_q;
    mot_load_o = 1'b0;
    blk_load_o = 1'b0;
    tmr_clr_o  = 1'b0;
    strobe     = 1'b0;
    if (sync_rise_i) begin
      st_d      = ST_ARMED;
      tmr_clr_o = 1'b1;
    end else begin
      unique case (st_q)
        ST_ARMED: if (vds_on_i && !sync_i) begin
          st_d       = ST_MOT;
          mot_load_o = 1'b1;
        end
        ST_MOT: if (mot_done_i) begin
          strobe = 1'b1;
          if (vds_off_i) begin
            st_d       = ST_BLANK;
            blk_load_o = 1'b1;
          end else begin
            st_d = ST_ON;
          end
        end
        ST_ON: if (vds_off_i) begin
          st_d       = ST_BLANK;
          blk_load_o = 1'b1;
        end
        ST_BLANK: if (vds_rst_i || blk_done_i) st_d = ST_ARMED;
        default: st_d = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_ARMED;
      me_q <= 1'b0;
      mv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      me_q <= strobe;
      if (strobe) mv_q <= vds_off_i;
    end
  end

  assign mot_run_o     = (st_q == ST_MOT);
  assign blk_run_o     = (st_q == ST_BLANK);
  assign gate_on_o     = (st_q == ST_MOT) || (st_q == ST_ON);
  assign mot_end_o     = me_q;
  assign mot_end_val_o = mv_q;
  assign st_o          = st_q;
endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
  import sr_seq_pkg::*;
#(
  parameter int MOT_W    = 8,
  parameter int BLK_W    = 10,
  parameter int CLK_KHZ  = 50000,
  parameter int BLANK_NS = 17000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vds_on_i,
  input  logic             vds_off_i,
  input  logic             vds_rst_i,
  input  logic             sync_i,
  input  logic             allow_i,
  input  logic [MOT_W-1:0] mot_cyc_i,
  input  logic [BLK_W-1:0] blank_cyc_i,
  output logic             gate_o,
  output logic             mot_end_o,
  output logic             mot_end_val_o
);
  localparam longint BLANK_DEF_L = longint'(CLK_KHZ) * longint'(BLANK_NS) / 64'd1000000;
  localparam logic [BLK_W-1:0] BLANK_DEF = BLK_W'(BLANK_DEF_L);

  logic       sync_rise;
  logic       mot_load, blk_load, tmr_clr, mot_run, blk_run;
  logic       mot_done, blk_done, gate_on;
  logic [BLK_W-1:0] blank_val;
  sr_st_e     st_q;

  assign blank_val = (blank_cyc_i == '0) ? BLANK_DEF : blank_cyc_i;

  sr_edge_det u_sync_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_i),
    .rise_o (sync_rise)
  );

  sr_down_timer #(.W(MOT_W)) u_mot_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .load_i (mot_load),
    .val_i  (mot_cyc_i),
    .run_i  (mot_run),
    .done_o (mot_done)
  );

  sr_down_timer #(.W(BLK_W)) u_blk_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tmr_clr),
    .load_i (blk_load),
    .val_i  (blank_val),
    .run_i  (blk_run),
    .done_o (blk_done)
  );

  sr_seq_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .vds_on_i      (vds_on_i),
    .vds_off_i     (vds_off_i),
    .vds_rst_i     (vds_rst_i),
    .sync_i        (sync_i),
    .sync_rise_i   (sync_rise),
    .mot_done_i    (mot_done),
    .blk_done_i    (blk_done),
    .mot_load_o    (mot_load),
    .blk_load_o    (blk_load),
    .tmr_clr_o     (tmr_clr),
    .mot_run_o     (mot_run),
    .blk_run_o     (blk_run),
    .gate_on_o     (gate_on),
    .mot_end_o     (mot_end_o),
    .mot_end_val_o (mot_end_val_o),
    .st_o          (st_q)
  );

  // sync level overrides without waiting for a clock edge
  assign gate_o = gate_on & allow_i & ~sync_i;
endmodule

// File: rtl/sr_gate_seq_chk.sv
module sr_gate_seq_chk
  import sr_seq_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input logic   vds_on_i,
  input logic   vds_off_i,
  input logic   vds_rst_i,
  input logic   sync_i,
  input logic   gate_o,
  input logic   mot_end_o,
  input sr_st_e st_q
);
  a_r1_turn_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARMED && vds_on_i && !sync_i) |=> (st_q == ST_MOT));

  a_r3_turn_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ON && vds_off_i && !sync_i) |=> !gate_o);

  a_r5_blank_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BLANK && vds_rst_i && !sync_i) |=> (st_q == ST_ARMED));

  a_r8_sync_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_i) |=> (st_q == ST_ARMED && !gate_o));

  a_r10_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mot_end_o |=> !mot_end_o);
endmodule

bind sr_gate_seq sr_gate_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vds_on_i  (vds_on_i),
  .vds_off_i (vds_off_i),
  .vds_rst_i (vds_rst_i),
  .sync_i    (sync_i),
  .gate_o    (gate_o),
  .mot_end_o (mot_end_o),
  .st_q      (st_q)
);

// File: tb/sr_gate_seq_bench.sv
`timescale 1ns/1ps
module sr_gate_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vds_on_i = 1'b0, vds_off_i = 1'b0, vds_rst_i = 1'b0;
  logic       sync_i = 1'b0, allow_i = 1'b1;
  logic [7:0] mot_cyc_i = 8'd4;
  logic [9:0] blank_cyc_i = 10'd6;
  logic       gate_o, mot_end_o, mot_end_val_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  sr_gate_seq u_sr_gate_seq (
    .clk_i, .rst_ni, .vds_on_i, .vds_off_i, .vds_rst_i, .sync_i, .allow_i,
    .mot_cyc_i, .blank_cyc_i, .gate_o, .mot_end_o, .mot_end_val_o
  );

  // {on, off, rst, sync, allow, exp_gate, exp_me, exp_mv, req}
  localparam logic [11:0] VEC [0:28] = '{
    12'b10001_100_0001, // R1 turn on
    12'b01001_100_0010, // R2 off ignored
    12'b01001_100_0010, // R2
    12'b00001_100_0010, // R2
    12'b00001_110_1010, // R10 strobe, val 0
    12'b00001_100_1010, // R10 strobe gone
    12'b01001_000_0011, // R3 off after mot
    12'b10001_000_0100, // R4 blanked
    12'b10001_000_0100, // R4
    12'b00101_000_0101, // R5 early re-arm
    12'b10001_100_0101, // R5 turn on again
    12'b01001_100_0010, // R2
    12'b01001_100_0010, // R2
    12'b01001_100_0010, // R2
    12'b01001_011_1010, // R10 strobe, val 1, R3 off at expiry
    12'b10001_000_0100, // R4
    12'b10001_000_0100, // R4
    12'b10001_000_0100, // R4
    12'b10001_000_0100, // R4
    12'b10001_000_0100, // R4
    12'b10001_000_0100, // R4 window end edge
    12'b10001_100_0100, // R4 on after window
    12'b00011_000_0111, // R7 sync forces low
    12'b10011_000_1000, // R8 level blocks turn on
    12'b10001_100_1000, // R8 no blanking after sync
    12'b00000_000_1001, // R9 allow masks
    12'b00001_100_1001, // R9 restored
    12'b00011_000_0111, // R7 sync during mot
    12'b00001_000_1010  // R10 no strobe after abort
  };

  function automatic string rtag(int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic drive(logic on, logic off, logic rs, logic sy, logic al);
    vds_on_i = on; vds_off_i = off; vds_rst_i = rs; sync_i = sy; allow_i = al;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", "reset gate", gate_o, 1'b0);
    chk("R10", "reset strobe", mot_end_o, 1'b0);
    rst_ni = 1'b1;
    tick();

    for (int i = 0; i < 29; i++) begin
      drive(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7]);
      tick();
      chk(rtag(int'(VEC[i][3:0])), $sformatf("vec %0d gate", i), gate_o, VEC[i][6]);
      chk(rtag(int'(VEC[i][3:0])), $sformatf("vec %0d strobe", i), mot_end_o, VEC[i][5]);
      if (VEC[i][5]) chk("R10", $sformatf("vec %0d val", i), mot_end_val_o, VEC[i][4]);
    end

    // R8: sync edge during blanking re-arms at once
    drive(1, 0, 0, 0, 1); tick();
    chk("R1", "directed turn on", gate_o, 1'b1);
    drive(0, 1, 0, 0, 1);
    for (int k = 0; k < 4; k++) tick();
    chk("R3", "in blank", gate_o, 1'b0);
    drive(0, 0, 0, 1, 1); tick();
    drive(1, 0, 0, 0, 1); tick();
    chk("R8", "sync edge ends blanking", gate_o, 1'b1);

    // R6: zero blanking input selects 850 cycles
    blank_cyc_i = '0;
    drive(0, 1, 0, 0, 1);
    for (int k = 0; k < 4; k++) tick();
    chk("R6", "default blank entered", gate_o, 1'b0);
    drive(1, 0, 0, 0, 1);
    for (int k = 1; k <= 851; k++) begin
      tick();
      if (k == 849) chk("R6", "blank cycle 849", gate_o, 1'b0);
      if (k == 850) chk("R6", "blank end edge", gate_o, 1'b0);
      if (k == 851) chk("R6", "on after default blank", gate_o, 1'b1);
    end

    // R2: mot of zero acts as one cycle
    mot_cyc_i = 8'd0;
    blank_cyc_i = 10'd6;
    drive(0, 0, 0, 1, 1); tick();
    drive(1, 0, 0, 0, 1); tick();
    chk("R2", "zero mot on", gate_o, 1'b1);
    drive(0, 0, 0, 0, 1); tick();
    chk("R10", "zero mot strobe", mot_end_o, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule